// File: doc/BRIEF.md
# Per-Lane Parity Generate/Check Unit

This block is the parity logic that sits between the two stored data paths of a bidirectional bus transceiver with two ports, A and B. Each port is split into lanes. A lane holds a data byte and one parity bit. For every lane and every port, the block either works out the parity bit that goes out on that port, or checks the 9-bit group arriving on that port and reports a mismatch on an active-low error flag.

Each port's role comes from its drive enable. A port whose outputs are driven gets a generated parity bit, computed over the data from the opposite port. A port whose outputs are not driven is receiving, so its incoming group is checked. A bypass select turns all parity handling off. In bypass the parity bits are carried across as ordinary data and no error flag is driven. A polarity input chooses whether the rule is even or odd parity.

The block is purely combinational. It has no storage and no timing of its own.

Top module: `parity_unit`

## Requirements
- R1: When `bypass` is 1, `a_par_out` equals `b_par_in` and `b_par_out` equals `a_par_in` bit for bit, and both `a_err_oe` and `b_err_oe` are 0.
- R2: When `bypass` is 0, `a_drv_en` is 1 and `b_drv_en` is 0, each lane of `a_par_out` is generated over that lane of `b_data`, and port B's incoming groups are checked (`b_err_oe`=1, `a_err_oe`=0).
- R3: When `bypass` is 0, `b_drv_en` is 1 and `a_drv_en` is 0, each lane of `b_par_out` is generated over that lane of `a_data`, and port A's incoming groups are checked (`a_err_oe`=1, `b_err_oe`=0).
- R4: When `bypass` is 0 and both drive enables are 0, both ports are checked (`a_err_oe`=`b_err_oe`=1).
- R5: When `bypass` is 0 and both drive enables are 1, both ports' parity bits are generated and neither error flag is driven.
- R6: A generated bit makes the 8 data bits plus the bit hold an even number of ones when `odd_sel`=0, and an odd number when `odd_sel`=1.
- R7: On a checked port, `err_n[i]` is 1 when lane i's data bits plus its parity bit meet the selected rule, and 0 when they do not.
- R8: Lanes are independent. Lane i's data occupies bits [8i+7:8i] and its parity bit is bit i. An error in one lane affects only that lane's flag.
- R9: An error flag whose enable is 0 reads all ones.
- R10: `a_par_oe` equals `a_drv_en`, `b_par_oe` equals `b_drv_en`, and a parity output that is not driven reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bypass | input | 1 | 1 = parity off, parity bits pass through as data |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| a_drv_en | input | 1 | Port A outputs driven |
| b_drv_en | input | 1 | Port B outputs driven |
| a_data | input | 16 | Port A data, 8 bits per lane |
| a_par_in | input | 2 | Port A parity bit per lane |
| b_data | input | 16 | Port B data, 8 bits per lane |
| b_par_in | input | 2 | Port B parity bit per lane |
| a_par_out | output | 2 | Parity bits to drive on port A |
| a_par_oe | output | 1 | Enable for `a_par_out` |
| a_err_n | output | 2 | Active-low error per lane, port A |
| a_err_oe | output | 1 | Enable for `a_err_n` |
| b_par_out | output | 2 | Parity bits to drive on port B |
| b_par_oe | output | 1 | Enable for `b_par_out` |
| b_err_n | output | 2 | Active-low error per lane, port B |
| b_err_oe | output | 1 | Enable for `b_err_n` |

## Verification
The bench steps through all sixteen combinations of bypass, polarity and the two enables. It pairs each combination with data that has an even or odd number of ones, and with parity bits that are right or wrong.

A design that mixed up the source side would generate parity over the port's own data. The tests use opposite ports with different weights, so that mistake shows up. An inverted polarity sense would flip every generated bit and every flag. Lane-crossed indexing would flag the wrong lane when only one lane is corrupted. A design that still drives error flags in bypass, or drives them on a port that is generating, would show the flag enable set where it must be clear.

// File: rtl/parity_pkg.sv
package parity_pkg;
  typedef enum logic [1:0] {
    ROLE_IDLE  = 2'd0,
    ROLE_PASS  = 2'd1,
    ROLE_GEN   = 2'd2,
    ROLE_CHECK = 2'd3
  } port_role_e;

  function automatic logic par_bit(input logic [63:0] v, input logic odd);
    return (^v) ^ odd;
  endfunction

  function automatic logic group_ok(input logic [63:0] v, input logic p, input logic odd);
    return ((^v) ^ p) == odd;
  endfunction
endpackage

// File: rtl/parity_role_dec.sv
module parity_role_dec
  import parity_pkg::*;
(
  input  logic       bypass,
  input  logic       drv_en,
  output port_role_e role
);
  always_comb begin
    if (bypass) role = drv_en ? ROLE_PASS : ROLE_IDLE;
    else        role = drv_en ? ROLE_GEN  : ROLE_CHECK;
  end
endmodule

// File: rtl/parity_lane.sv
module parity_lane
  import parity_pkg::*;
#(
  parameter int W = 8
) (
  input  port_role_e   role,
  input  logic         odd_sel,
  input  logic [W-1:0] own_data,
  input  logic         own_par,
  input  logic [W-1:0] far_data,
  input  logic         far_par,
  output logic         par_out,
  output logic         err_n
);
  logic gen_bit, chk_ok;

  assign gen_bit = par_bit(64'(far_data), odd_sel);
  assign chk_ok  = group_ok(64'(own_data), own_par, odd_sel);

  always_comb begin
    unique case (role)
      ROLE_PASS: par_out = far_par;
      ROLE_GEN:  par_out = gen_bit;
      default:   par_out = 1'b0;
    endcase
    err_n = (role == ROLE_CHECK) ? chk_ok : 1'b1;
  end
endmodule

// File: rtl/parity_unit.sv
module parity_unit
  import parity_pkg::*;
#(
  parameter int LANES = 2,
  parameter int W     = 8
) (
  input  logic               bypass,
  input  logic               odd_sel,
  input  logic               a_drv_en,
  input  logic               b_drv_en,
  input  logic [LANES*W-1:0] a_data,
  input  logic [LANES-1:0]   a_par_in,
  input  logic [LANES*W-1:0] b_data,
  input  logic [LANES-1:0]   b_par_in,
  output logic [LANES-1:0]   a_par_out,
  output logic               a_par_oe,
  output logic [LANES-1:0]   a_err_n,
  output logic               a_err_oe,
  output logic [LANES-1:0]   b_par_out,
  output logic               b_par_oe,
  output logic [LANES-1:0]   b_err_n,
  output logic               b_err_oe
);
  port_role_e a_role, b_role;

  parity_role_dec u_dec_a (.bypass(bypass), .drv_en(a_drv_en), .role(a_role));
  parity_role_dec u_dec_b (.bypass(bypass), .drv_en(b_drv_en), .role(b_role));

  assign a_par_oe = a_drv_en;
  assign b_par_oe = b_drv_en;
  assign a_err_oe = (a_role == ROLE_CHECK);
  assign b_err_oe = (b_role == ROLE_CHECK);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    parity_lane #(.W(W)) u_a (
      .role(a_role), .odd_sel(odd_sel),
      .own_data(a_data[i*W +: W]), .own_par(a_par_in[i]),
      .far_data(b_data[i*W +: W]), .far_par(b_par_in[i]),
      .par_out(a_par_out[i]), .err_n(a_err_n[i]));
    parity_lane #(.W(W)) u_b (
      .role(b_role), .odd_sel(odd_sel),
      .own_data(b_data[i*W +: W]), .own_par(b_par_in[i]),
      .far_data(a_data[i*W +: W]), .far_par(a_par_in[i]),
      .par_out(b_par_out[i]), .err_n(b_err_n[i]));
  end
endmodule

// File: rtl/parity_unit_chk.sv
module parity_unit_chk #(
  parameter int LANES = 2,
  parameter int W     = 8
) (
  input logic               bypass,
  input logic               odd_sel,
  input logic               a_drv_en,
  input logic               b_drv_en,
  input logic [LANES*W-1:0] a_data,
  input logic [LANES-1:0]   a_par_in,
  input logic [LANES*W-1:0] b_data,
  input logic [LANES-1:0]   b_par_in,
  input logic [LANES-1:0]   a_par_out,
  input logic [LANES-1:0]   a_err_n,
  input logic               a_err_oe,
  input logic [LANES-1:0]   b_par_out,
  input logic [LANES-1:0]   b_err_n,
  input logic               b_err_oe
);
  always_comb begin
    if (bypass) begin
      a_r1_no_err_drive: assert (!a_err_oe && !b_err_oe);
      if (a_drv_en) a_r1_feed_a: assert (a_par_out == b_par_in);
      if (b_drv_en) a_r1_feed_b: assert (b_par_out == a_par_in);
    end else begin
      a_r4_check_when_idle: assert (a_err_oe == !a_drv_en && b_err_oe == !b_drv_en);
    end
    if (a_drv_en) a_r5_gen_no_err_a: assert (!a_err_oe);
    if (b_drv_en) a_r5_gen_no_err_b: assert (!b_err_oe);
    if (!a_err_oe) a_r9_quiet_a: assert (&a_err_n);
    if (!b_err_oe) a_r9_quiet_b: assert (&b_err_n);
    for (int i = 0; i < LANES; i++) begin
      if (a_err_oe)
        a_r7_flag_a: assert ((($countones({a_data[i*W +: W], a_par_in[i]}) % 2) == int'(odd_sel)) == a_err_n[i]);
      if (b_err_oe)
        a_r7_flag_b: assert ((($countones({b_data[i*W +: W], b_par_in[i]}) % 2) == int'(odd_sel)) == b_err_n[i]);
      if (!bypass && b_drv_en)
        a_r6_gen_b: assert (($countones({a_data[i*W +: W], b_par_out[i]}) % 2) == int'(odd_sel));
      if (!bypass && a_drv_en)
        a_r6_gen_a: assert (($countones({b_data[i*W +: W], a_par_out[i]}) % 2) == int'(odd_sel));
    end
  end
endmodule

bind parity_unit parity_unit_chk #(.LANES(LANES), .W(W)) u_chk (
  .bypass(bypass), .odd_sel(odd_sel), .a_drv_en(a_drv_en), .b_drv_en(b_drv_en),
  .a_data(a_data), .a_par_in(a_par_in), .b_data(b_data), .b_par_in(b_par_in),
  .a_par_out(a_par_out), .a_err_n(a_err_n), .a_err_oe(a_err_oe),
  .b_par_out(b_par_out), .b_err_n(b_err_n), .b_err_oe(b_err_oe));

// File: tb/parity_unit_test.sv
module parity_unit_test;
  localparam int L = 2;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic bypass, odd_sel, a_drv_en, b_drv_en;
  logic [L*W-1:0] a_data, b_data;
  logic [L-1:0] a_par_in, b_par_in;
  logic [L-1:0] a_par_out, a_err_n, b_par_out, b_err_n;
  logic a_par_oe, a_err_oe, b_par_oe, b_err_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  parity_unit uut (
    .bypass(bypass), .odd_sel(odd_sel), .a_drv_en(a_drv_en), .b_drv_en(b_drv_en),
    .a_data(a_data), .a_par_in(a_par_in), .b_data(b_data), .b_par_in(b_par_in),
    .a_par_out(a_par_out), .a_par_oe(a_par_oe), .a_err_n(a_err_n), .a_err_oe(a_err_oe),
    .b_par_out(b_par_out), .b_par_oe(b_par_oe), .b_err_n(b_err_n), .b_err_oe(b_err_oe));

  function automatic int ones(input logic [W-1:0] v);
    int c = 0;
    for (int k = 0; k < W; k++) if (v[k]) c++;
    return c;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, evaluated from the requirement text
  task automatic check_all();
    logic [L-1:0] e_apo, e_bpo, e_aerr, e_berr;
    int a_chk, b_chk;
    a_chk = (!bypass && !a_drv_en) ? 1 : 0;   // R2 R3 R4 R5
    b_chk = (!bypass && !b_drv_en) ? 1 : 0;
    for (int i = 0; i < L; i++) begin
      if (!a_drv_en) e_apo[i] = 1'b0;
      else if (bypass) e_apo[i] = b_par_in[i];
      else e_apo[i] = ((ones(b_data[i*W +: W]) + (odd_sel ? 1 : 0)) % 2) == 1;
      if (!b_drv_en) e_bpo[i] = 1'b0;
      else if (bypass) e_bpo[i] = a_par_in[i];
      else e_bpo[i] = ((ones(a_data[i*W +: W]) + (odd_sel ? 1 : 0)) % 2) == 1;
      e_aerr[i] = a_chk == 0 ? 1'b1 :
                  (((ones(a_data[i*W +: W]) + a_par_in[i]) % 2) == (odd_sel ? 1 : 0));
      e_berr[i] = b_chk == 0 ? 1'b1 :
                  (((ones(b_data[i*W +: W]) + b_par_in[i]) % 2) == (odd_sel ? 1 : 0));
    end
    cmp(bypass ? "R1 a_par_out" : "R6 a_par_out", a_par_out, e_apo);
    cmp(bypass ? "R1 b_par_out" : "R6 b_par_out", b_par_out, e_bpo);
    cmp("R10 a_par_oe", a_par_oe, a_drv_en);
    cmp("R10 b_par_oe", b_par_oe, b_drv_en);
    cmp("R4 a_err_oe", a_err_oe, a_chk);
    cmp("R4 b_err_oe", b_err_oe, b_chk);
    cmp(a_chk != 0 ? "R7 a_err_n" : "R9 a_err_n", a_err_n, e_aerr);
    cmp(b_chk != 0 ? "R7 b_err_n" : "R9 b_err_n", b_err_n, e_berr);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bypass = 0; odd_sel = 0; a_drv_en = 0; b_drv_en = 0;
    a_data = '0; b_data = '0; a_par_in = '0; b_par_in = '0;
    repeat (2) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all();  // initial state: both checked, all groups even, flags high
    // all sixteen control combinations with several data patterns
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 4; p++) begin
        @(posedge clk); #1;
        {bypass, odd_sel, a_drv_en, b_drv_en} = 4'(m);
        case (p)
          0: begin a_data = 16'h0301; b_data = 16'h0700; a_par_in = 2'b01; b_par_in = 2'b10; end
          1: begin a_data = 16'hFF7F; b_data = 16'h0F01; a_par_in = 2'b11; b_par_in = 2'b00; end
          2: begin a_data = 16'h8001; b_data = 16'hFE03; a_par_in = 2'b10; b_par_in = 2'b01; end
          default: begin a_data = 16'(m * 16'h1357); b_data = ~a_data; a_par_in = 2'(p); b_par_in = 2'(m); end
        endcase
        @(negedge clk);
        check_all();
      end
    end
    // R8: corrupt lane 1 only on a checked port
    @(posedge clk); #1;
    {bypass, odd_sel, a_drv_en, b_drv_en} = 4'b0000;
    a_data = 16'h0300; a_par_in = 2'b10; b_data = 16'h0001; b_par_in = 2'b01;
    @(negedge clk);
    cmp("R8 a lane1 only", a_err_n, 2'b01);
    cmp("R8 b clean", b_err_n, 2'b11);
    check_all();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule